// File: doc/BRIEF.md
# PWM-Dithered DAC Code Generator

This block produces one 8-bit DAC code per system clock from a 16-bit output value. It resolves the 8 fractional bits of the value with ordered pulse-width dithering. The upper byte gives a base level. The lower byte gives how many clocks of every 256-clock frame carry the next level up. The slow analog stage after the converter averages the two levels, so the converter behaves like a 16-bit one that keeps 8-bit switching activity.

The value in effect is copied from the value input only at the end of a sample period. The sample period is set in clocks by a period input and spans a whole number of frames. When a copy is taken, a done flag rises. Software or a streaming source uses that flag to present the next sample, and then clears it with a one-cycle acknowledge. A low run enable holds the block in reset. In that state the flag is low and the value input is copied on every clock, so the first frame after enabling already uses it.

Top module: `dither_dac_gen`

## Requirements
- R1: The code is the base level value[15:8] during the first 256 − value[7:0] clocks of each 256-clock frame, and base+1 during the last value[7:0] clocks; a low byte of 0 gives the base level for the whole frame.
- R2: A value of 0x0001 yields code 0x00 for 255 clocks followed by 0x01 for one clock, repeating every 256 clocks.
- R3: When the base level is 0xFF the code stays 0xFF in every clock and never wraps to 0x00.
- R4: Within one frame the code changes at most twice: once at the start of the frame and once where the upper level begins.
- R5: The value input is copied only in the clock that ends a sample period; value changes at any other time have no effect on the code until that boundary, and each copy restarts the frame at its first clock.
- R6: The sample period in clocks is period[15:8] × 256, with period[7:0] ignored; a period of 0x0000 means 65536 clocks and a nonzero period below 0x0100 means 256 clocks.
- R7: In the clock after a sample period ends, the done flag is high.
- R8: An acknowledge pulse clears the done flag in the next clock, unless a sample period ends in the same clock, in which case the flag stays high.
- R9: While run enable is low, the done flag is low, the value input is copied every clock and the frame position is held at its first clock; after run enable goes high, the first frame begins with the value present in the last disabled clock.
- R10: The copied value is not cleared, so a value input left unchanged gives the same code sequence in every sample period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| run_en | input | 1 | High to run; low holds the block in reset and tracks the value input |
| period_i | input | 16 | Sample period in clocks, upper byte in units of 256 clocks |
| value_i | input | 16 | Output value: upper byte base level, lower byte dither count |
| ack_i | input | 1 | One-cycle pulse that clears the done flag |
| dac_code_o | output | 8 | DAC code for the current clock |
| done_o | output | 1 | Set when a new value has been copied at a sample-period end |

## Verification
The assertions assume the period input is steady while run enable is high, because the frame counter is compared against it on every clock. The bench changes the period only while the block is disabled. The assertions also assume run enable is low for at least one clock before the first enabled clock, so the history they look back on is defined. The bench starts every scenario with disabled clocks. The value input and the acknowledge are left unconstrained, and the bench moves the value on every clock in several scenarios, so that the latch point is visible.

// File: rtl/ddac_pkg.sv
package ddac_pkg;

  // Configuration point for the whole block.
  localparam int unsigned VAL_W  = 16;             // output value width
  localparam int unsigned PH_W   = 8;              // frame position width (frame = 2**PH_W clocks)
  localparam int unsigned CODE_W = VAL_W - PH_W;   // DAC code width
  localparam int unsigned FRM_W  = VAL_W - PH_W;   // frames-per-period field width

  typedef logic [VAL_W-1:0]  word_t;
  typedef logic [PH_W-1:0]   phase_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [FRM_W-1:0]  frame_t;

  // Index of the last frame in a sample period. Zero means the largest period,
  // and a period shorter than one frame is raised to one frame.
  function automatic frame_t last_frame_of(word_t per);
    frame_t nfr;
    nfr = per[VAL_W-1:PH_W];
    if (per == '0)       return '1;
    else if (nfr == '0)  return '0;
    else                 return nfr - frame_t'(1);
  endfunction

  // First frame position at which the upper level is driven.
  function automatic logic [PH_W:0] rise_point(phase_t lo);
    logic [PH_W:0] full;
    full = '0;
    full[PH_W] = 1'b1;
    return full - {1'b0, lo};
  endfunction

  // Code for a given value at a given frame position, saturating at full scale.
  function automatic code_t dither_code(word_t v, phase_t ph);
    code_t  base;
    phase_t lo;
    logic   upper;
    base  = v[VAL_W-1:PH_W];
    lo    = v[PH_W-1:0];
    upper = ({1'b0, ph} >= rise_point(lo));
    if (upper && (base != '1)) return base + code_t'(1);
    else                       return base;
  endfunction

endpackage

// File: rtl/ddac_period_timer.sv
module ddac_period_timer
  import ddac_pkg::*;
(
  input  logic   clk,
  input  logic   run_en,
  input  word_t  period_i,
  output phase_t phase_o,
  output logic   end_o
);

  phase_t phase_q;
  frame_t frame_q;
  frame_t last_frame;
  logic   frame_wrap;

  assign last_frame = last_frame_of(period_i);
  assign frame_wrap = (phase_q == '1);
  assign end_o      = run_en && frame_wrap && (frame_q >= last_frame);
  assign phase_o    = phase_q;

  always_ff @(posedge clk) begin
    if (!run_en) begin
      phase_q <= '0;
      frame_q <= '0;
    end else if (end_o) begin
      phase_q <= '0;
      frame_q <= '0;
    end else begin
      phase_q <= phase_q + phase_t'(1);
      if (frame_wrap) frame_q <= frame_q + frame_t'(1);
    end
  end

  // R6: a period always ends on the last clock of a whole frame
  a_r6_end_on_frame_edge: assert property (@(posedge clk) disable iff (!run_en)
    end_o |-> (phase_o == '1));

  // R6: with a steady period the frame index never passes the last frame
  a_r6_frame_bound: assert property (@(posedge clk) disable iff (!run_en)
    $stable(period_i) |-> (frame_q <= last_frame));

  // R5: the frame position restarts after each period end
  a_r5_restart: assert property (@(posedge clk) disable iff (!run_en)
    end_o |=> (phase_o == '0));

endmodule

// File: rtl/ddac_sample_latch.sv
module ddac_sample_latch
  import ddac_pkg::*;
(
  input  logic  clk,
  input  logic  run_en,
  input  word_t value_i,
  input  logic  load_i,
  input  logic  ack_i,
  output word_t held_o,
  output logic  done_o
);

  word_t held_q;
  logic  done_q;

  always_ff @(posedge clk) begin
    if (!run_en) begin
      held_q <= value_i;
      done_q <= 1'b0;
    end else begin
      if (load_i) held_q <= value_i;
      if (load_i)     done_q <= 1'b1;
      else if (ack_i) done_q <= 1'b0;
    end
  end

  assign held_o = held_q;
  assign done_o = done_q;

  // R7: a period end raises the flag
  a_r7_flag_on_end: assert property (@(posedge clk) disable iff (!run_en)
    load_i |=> done_o);

  // R8: acknowledge without a coinciding end clears the flag
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!run_en)
    (done_o && ack_i && !load_i) |=> !done_o);

  // R8: the flag only rises because of a period end
  a_r8_rise_needs_end: assert property (@(posedge clk) disable iff (!run_en)
    $rose(done_o) |-> $past(load_i));

endmodule

// File: rtl/ddac_frame_pwm.sv
module ddac_frame_pwm
  import ddac_pkg::*;
(
  input  logic   clk,
  input  logic   run_en,
  input  word_t  held_i,
  input  phase_t phase_i,
  output code_t  code_o
);

  assign code_o = dither_code(held_i, phase_i);

  // R4: the code moves only at frame start or where the upper level begins
  a_r4_two_steps: assert property (@(posedge clk) disable iff (!run_en)
    !$stable(code_o) |->
      ((phase_i == '0) || ({1'b0, phase_i} == rise_point(held_i[PH_W-1:0]))));

endmodule

// File: rtl/dither_dac_gen.sv
module dither_dac_gen
  import ddac_pkg::*;
(
  input  logic              clk,
  input  logic              run_en,
  input  logic [VAL_W-1:0]  period_i,
  input  logic [VAL_W-1:0]  value_i,
  input  logic              ack_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              done_o
);

  // Internal events brought out as named wires.
  logic   period_end;
  phase_t frame_pos;
  word_t  held_val;

  ddac_period_timer u_timer (
    .clk      (clk),
    .run_en   (run_en),
    .period_i (period_i),
    .phase_o  (frame_pos),
    .end_o    (period_end)
  );

  ddac_sample_latch u_latch (
    .clk     (clk),
    .run_en  (run_en),
    .value_i (value_i),
    .load_i  (period_end),
    .ack_i   (ack_i),
    .held_o  (held_val),
    .done_o  (done_o)
  );

  ddac_frame_pwm u_pwm (
    .clk     (clk),
    .run_en  (run_en),
    .held_i  (held_val),
    .phase_i (frame_pos),
    .code_o  (dac_code_o)
  );

  // R5: the value in effect only changes at a period end
  a_r5_hold_between: assert property (@(posedge clk) disable iff (!run_en)
    !period_end |=> $stable(held_val));

  // R3: a full-scale base level never wraps
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!run_en)
    (held_val[VAL_W-1:PH_W] == '1) |-> (dac_code_o == '1));

endmodule

// File: tb/tb_dither_dac_gen.sv
module tb_dither_dac_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        run_en = 1'b0;
  logic [15:0] period_i = 16'h0100;
  logic [15:0] value_i = 16'h0000;
  logic        ack_i = 1'b0;
  logic [7:0]  dac_code_o;
  logic        done_o;

  dither_dac_gen dut (
    .clk        (clk),
    .run_en     (run_en),
    .period_i   (period_i),
    .value_i    (value_i),
    .ack_i      (ack_i),
    .dac_code_o (dac_code_o),
    .done_o     (done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] code;
    logic       done;
    string      req;
  } exp_t;

  exp_t  q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R9";
  bit    finished = 0;

  // Bench model state, stated from the requirements.
  int m_val = 0;
  int m_pos = 0;
  int m_per = 256;
  bit m_done = 0;

  function automatic int period_clocks(int x);
    if (x == 0) return 65536;
    if (x < 256) return 256;
    return (x / 256) * 256;
  endfunction

  function automatic int exp_code(int v, int pos);
    int base, cnt, slot;
    base = v / 256;
    cnt  = v % 256;
    slot = pos % 256;
    if ((slot + cnt >= 256) && (base < 255)) return base + 1;
    return base;
  endfunction

  task automatic set_period(input int x);
    period_i = 16'(x);
    m_per = period_clocks(x);
  endtask

  task automatic step(input bit en, input int val, input bit ack);
    exp_t e;
    run_en  = en;
    value_i = 16'(val);
    ack_i   = ack;
    @(posedge clk);
    if (!en) begin
      m_val = val; m_pos = 0; m_done = 0;
    end else if (m_pos == m_per - 1) begin
      m_val = val; m_pos = 0; m_done = 1;
    end else begin
      m_pos++;
      if (ack) m_done = 0;
    end
    #1;
    e.code = 8'(exp_code(m_val, m_pos));
    e.done = m_done;
    e.req  = cur_req;
    q.push_back(e);
    ack_i = 1'b0;
  endtask

  // Monitor: pops one expectation per clock, away from the active edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (dac_code_o !== e.code || done_o !== e.done) begin
        n_fail++;
        $display("FAIL %s: code=%h done=%b expected code=%h done=%b",
                 e.req, dac_code_o, done_o, e.code, e.done);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state, value tracked while disabled
    cur_req = "R9";
    set_period(16'h0100);
    for (int i = 0; i < 6; i++) step(0, 16'h3456 + i * 16'h0100, 0);

    // R2 and R10: 0x0001 pattern, constant value over several periods
    cur_req = "R2,R10";
    step(0, 16'h0001, 0);
    for (int i = 0; i < 800; i++) step(1, 16'h0001, 0);

    // R1 and R4: mid-scale dither over two-frame periods
    cur_req = "R1,R4";
    set_period(16'h0200);
    step(0, 16'h80C0, 0);
    for (int i = 0; i < 1200; i++) step(1, 16'h80C0, 0);
    step(0, 16'h7FFF, 0);
    for (int i = 0; i < 600; i++) step(1, 16'h7FFF, 0);
    step(0, 16'h2200, 0);
    for (int i = 0; i < 600; i++) step(1, 16'h2200, 0);

    // R3: saturation at full scale
    cur_req = "R3";
    step(0, 16'hFF80, 0);
    for (int i = 0; i < 600; i++) step(1, 16'hFF80, 0);
    step(0, 16'hFFFF, 0);
    for (int i = 0; i < 400; i++) step(1, 16'hFFFF, 0);

    // R5: value moves often, only period ends take it
    cur_req = "R5";
    set_period(16'h0400);
    step(0, 16'h2010, 0);
    for (int i = 0; i < 3000; i++) step(1, (i / 37) * 1237 % 65536, 0);

    // R6: period derivation, value changing every clock exposes the latch point
    cur_req = "R6";
    set_period(16'h01FF);
    step(0, 16'h1234, 0);
    for (int i = 0; i < 800; i++) step(1, (i * 40503 + 7) % 65536, 0);
    set_period(16'h0005);
    step(0, 16'h4321, 0);
    for (int i = 0; i < 800; i++) step(1, (i * 24593 + 3) % 65536, 0);
    set_period(16'h0310);
    step(0, 16'h0A0A, 0);
    for (int i = 0; i < 1700; i++) step(1, (i * 3301 + 11) % 65536, 0);
    set_period(16'h0000);
    step(0, 16'h5555, 0);
    for (int i = 0; i < 66000; i++) step(1, (i * 977 + 5) % 65536, 0);

    // R7 and R8: acknowledge mid-period and coinciding with a period end
    cur_req = "R7,R8";
    set_period(16'h0100);
    step(0, 16'h4020, 0);
    for (int i = 0; i < 1500; i++) begin
      bit ack;
      ack = (m_pos == 100) || ((m_pos == 255) && (((i / 256) % 2) == 1));
      step(1, 16'h4020 + (i / 256), ack);
    end

    // R9: disabling mid-run drops the flag, re-enabling restarts the frame
    cur_req = "R9";
    for (int i = 0; i < 5; i++) step(0, 16'h6090 + i, 0);
    for (int i = 0; i < 600; i++) step(1, 16'h6094, 0);

    step(0, 16'h0000, 0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule